// File: doc/BRIEF.md
# Ballast Power-Mode Sequencer

This block sequences the supply-management states of a ballast gate-drive controller. It takes single-bit comparator flags that describe where the supply rail and the reference voltage sit. It also takes the low-side and high-side logic inputs that a microcontroller drives. From these it decides which supply mode the controller is in. For that mode it enables or disables the high-voltage start-up generator, the reference output (with its current strength and its sink clamp), the gate drivers, overcurrent protection and the supply switch of the two-point regulator.

The controller powers up in start-up mode. It moves to a save mode in which the start-up generator cycles between two supply levels. It enters operating mode only after a qualification interval has passed in save mode, the reference is good, and the microcontroller produces a falling edge on the high-side input. While in operating mode, a silent low-side input sends the block back to save mode, and a supply or reference fault sends it through a one-cycle shut-down state back to start-up. The qualification interval and the timeout are expressed in microseconds and converted into clock cycles from a clock-frequency parameter. Both logic inputs are synchronised before any edge is taken from them.

Top module: `ballast_mode_seq`

## Requirements
- R1: While reset is held and right after it, the block is in start-up mode. The `mode` output encodes the modes as 0 start-up, 1 save, 2 operating and 3 shut-down. In start-up the start-up generator is on, the reference is off, the sink clamp is on, and the drivers, overcurrent protection and supply switch are off.
- R2: In start-up, the block moves to save mode when `vcc_gt_on` is high. Until then it stays in start-up with the start-up outputs of R1.
- R3: In save mode, the reference is on at low current (`ref_hi_cur` low), the sink clamp is off, and the drivers, overcurrent protection and supply switch are off. The start-up generator is off on entry, turns off whenever `vcc_gt_on` is high, turns on when `vcc_gt_save` is low, and otherwise holds its state.
- R4: In save mode, `vcc_lt_refoff` high returns the block to start-up on the next clock. This takes precedence over an operating-mode entry that falls in the same cycle.
- R5: From save mode, the block enters operating mode only on a synchronised falling edge of `hs_in`. That edge must come after at least QUAL_US microseconds of uninterrupted save mode, and `ref_gt_hi` must be high at the edge. An edge that comes too early, or with the reference low, leaves the block in save mode.
- R6: In operating mode, the start-up generator is off, the reference is on at high current, the sink clamp is off, and the drivers and overcurrent protection are on.
- R7: In operating mode, if the synchronised `ls_in` shows no transition for IDLE_US microseconds, the block returns to save mode.
- R8: In operating mode, `vcc_lt_off` or `ref_lt_lo` high sends the block to shut-down on the next clock. This takes precedence over the inactivity timeout.
- R9: Shut-down lasts one clock. During it the drivers, overcurrent protection and supply switch are off and the start-up generator is on. The block then enters start-up.
- R10: In operating mode, `vcc_gt_prot` high turns the supply switch on at the next clock, with no edge needed.
- R11: In operating mode, on a synchronised falling edge of `ls_in`, the supply switch turns on if `vcc_gt_regon` is high and turns off if `vcc_lt_regoff` is high. With no falling edge and `vcc_gt_prot` low, the switch keeps its state.
- R12: The supply switch is off in every mode other than operating, and it is off on every entry to operating mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_gt_on | input | 1 | Supply above the turn-on level |
| vcc_gt_save | input | 1 | Supply above the save-mode restart level |
| vcc_lt_off | input | 1 | Supply below the turn-off level |
| vcc_lt_refoff | input | 1 | Supply below the reference-off level |
| vcc_gt_prot | input | 1 | Supply above the regulator protect level |
| vcc_gt_regon | input | 1 | Supply above the regulator switch-on level |
| vcc_lt_regoff | input | 1 | Supply below the regulator switch-off level |
| ref_gt_hi | input | 1 | Reference above its good level (4.6 V) |
| ref_lt_lo | input | 1 | Reference below its fault level (3.2 V) |
| ls_in | input | 1 | Low-side logic input, asynchronous |
| hs_in | input | 1 | High-side logic input, asynchronous |
| mode | output | 2 | Current mode: 0 start-up, 1 save, 2 operating, 3 shut-down |
| hv_start_en | output | 1 | High-voltage start-up generator enable |
| ref_en | output | 1 | Reference output enable |
| ref_hi_cur | output | 1 | Reference high-current select |
| ref_clamp_en | output | 1 | Reference sink clamp enable |
| drv_en | output | 1 | Gate-driver enable |
| ocp_en | output | 1 | Overcurrent protection enable |
| sup_sw_on | output | 1 | Two-point regulator supply switch control |

## Verification
Two decisions can land on the same clock in save mode: the return to start-up on a reference-off supply, and the entry to operating mode on a qualified high-side falling edge. The bench first lets the qualification interval expire. It then drops `hs_in`, waits two clocks until the synchronised falling edge is about to be registered, and raises `vcc_lt_refoff` for exactly that edge. The check passes only if the next mode is start-up and not operating. The supply-switch rules are probed separately, by combining low-side edges with each supply flag in operating mode.

// File: rtl/bms_pkg.sv
package bms_pkg;

   typedef enum logic [1:0] {
      MODE_START = 2'd0,
      MODE_SAVE  = 2'd1,
      MODE_RUN   = 2'd2,
      MODE_SHUT  = 2'd3
   } bms_mode_e;

   // microseconds to clock cycles for a clock given in kHz
   function automatic int us_to_cycles(input int clk_khz, input int us);
      return (clk_khz / 1000) * us;
   endfunction

endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] dly
);

   if (WIDTH < 1)  begin : g_bad_width  $error("bms_sync: WIDTH must be at least 1");  end
   if (STAGES < 2) begin : g_bad_stages $error("bms_sync: STAGES must be at least 2"); end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] sr_q;
      logic              prev_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            sr_q   <= '0;
            prev_q <= 1'b0;
         end else begin
            sr_q   <= {sr_q[STAGES-2:0], din[b]};
            prev_q <= sr_q[STAGES-1];
         end
      end

      assign lvl[b] = sr_q[STAGES-1];
      assign dly[b] = prev_q;
   end

endmodule

// File: rtl/bms_interval_timer.sv
module bms_interval_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   output logic done
);

   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit $error("bms_interval_timer: LIMIT must be at least 1"); end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt_q <= '0;
      end else if (cnt_q != CW'(LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == CW'(LIMIT));

   // a cleared interval cannot already be complete (R5, R7)
   p_clear_restarts_r5: assert property (@(posedge clk) disable iff (rst)
      clear |=> !done);

   // a completed interval stays complete until cleared (R7)
   p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
      (done && !clear) |=> done);

endmodule

// File: rtl/bms_supply_switch.sv
module bms_supply_switch (
   input  logic clk,
   input  logic rst,
   input  logic run_active,
   input  logic ls_fall,
   input  logic vcc_gt_prot,
   input  logic vcc_gt_regon,
   input  logic vcc_lt_regoff,
   output logic sw_q
);

   always_ff @(posedge clk) begin
      if (rst || !run_active) begin
         sw_q <= 1'b0;
      end else if (vcc_gt_prot) begin
         sw_q <= 1'b1;
      end else if (ls_fall) begin
         if (vcc_gt_regon) begin
            sw_q <= 1'b1;
         end else if (vcc_lt_regoff) begin
            sw_q <= 1'b0;
         end
      end
   end

   p_prot_immediate_r10: assert property (@(posedge clk) disable iff (rst)
      (run_active && vcc_gt_prot) |=> sw_q);

   p_hold_between_edges_r11: assert property (@(posedge clk) disable iff (rst)
      (run_active && !vcc_gt_prot && !ls_fall) |=> $stable(sw_q));

   p_clear_on_entry_r12: assert property (@(posedge clk) disable iff (rst)
      $rose(run_active) |-> !sw_q);

endmodule

// File: rtl/ballast_mode_seq.sv
module ballast_mode_seq
   import bms_pkg::*;
#(
   parameter int CLK_KHZ     = 100_000,
   parameter int QUAL_US     = 10,
   parameter int IDLE_US     = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       vcc_gt_on,
   input  logic       vcc_gt_save,
   input  logic       vcc_lt_off,
   input  logic       vcc_lt_refoff,
   input  logic       vcc_gt_prot,
   input  logic       vcc_gt_regon,
   input  logic       vcc_lt_regoff,
   input  logic       ref_gt_hi,
   input  logic       ref_lt_lo,
   input  logic       ls_in,
   input  logic       hs_in,
   output logic [1:0] mode,
   output logic       hv_start_en,
   output logic       ref_en,
   output logic       ref_hi_cur,
   output logic       ref_clamp_en,
   output logic       drv_en,
   output logic       ocp_en,
   output logic       sup_sw_on
);

   localparam int QUAL_CYC = us_to_cycles(CLK_KHZ, QUAL_US);
   localparam int IDLE_CYC = us_to_cycles(CLK_KHZ, IDLE_US);
   localparam int LS_BIT   = 0;
   localparam int HS_BIT   = 1;

   if (CLK_KHZ < 1000) begin : g_bad_clk  $error("ballast_mode_seq: CLK_KHZ must be at least 1000"); end
   if (QUAL_US < 1)    begin : g_bad_qual $error("ballast_mode_seq: QUAL_US must be at least 1");    end
   if (IDLE_US < 1)    begin : g_bad_idle $error("ballast_mode_seq: IDLE_US must be at least 1");    end

   // ---------------- input synchronisation and edge detection ----------------
   logic [1:0] in_lvl, in_dly;
   logic       ls_fall, ls_tog, hs_fall;

   bms_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk (clk),
      .rst (rst),
      .din ({hs_in, ls_in}),
      .lvl (in_lvl),
      .dly (in_dly)
   );

   assign ls_fall = in_dly[LS_BIT] & ~in_lvl[LS_BIT];
   assign ls_tog  = in_dly[LS_BIT] ^  in_lvl[LS_BIT];
   assign hs_fall = in_dly[HS_BIT] & ~in_lvl[HS_BIT];

   // ---------------- mode register ----------------
   bms_mode_e mode_q, mode_d;
   logic      qual_done, idle_done;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_START: if (vcc_gt_on) mode_d = MODE_SAVE;
         MODE_SAVE: begin
            if (vcc_lt_refoff)                           mode_d = MODE_START;
            else if (qual_done && ref_gt_hi && hs_fall)  mode_d = MODE_RUN;
         end
         MODE_RUN: begin
            if (vcc_lt_off || ref_lt_lo) mode_d = MODE_SHUT;
            else if (idle_done)          mode_d = MODE_SAVE;
         end
         MODE_SHUT: mode_d = MODE_START;
         default:   mode_d = MODE_START;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) mode_q <= MODE_START;
      else     mode_q <= mode_d;
   end

   // ---------------- qualification and inactivity intervals ----------------
   bms_interval_timer #(
      .LIMIT (QUAL_CYC)
   ) i_qual_timer (
      .clk   (clk),
      .rst   (rst),
      .clear (mode_q != MODE_SAVE),
      .done  (qual_done)
   );

   bms_interval_timer #(
      .LIMIT (IDLE_CYC)
   ) i_idle_timer (
      .clk   (clk),
      .rst   (rst),
      .clear ((mode_q != MODE_RUN) || ls_tog),
      .done  (idle_done)
   );

   // ---------------- start-up generator cycling in save mode ----------------
   logic hv_cyc_q;

   always_ff @(posedge clk) begin
      if (rst || (mode_q != MODE_SAVE)) begin
         hv_cyc_q <= 1'b0;
      end else if (vcc_gt_on) begin
         hv_cyc_q <= 1'b0;
      end else if (!vcc_gt_save) begin
         hv_cyc_q <= 1'b1;
      end
   end

   // ---------------- two-point regulator supply switch ----------------
   logic sw_q;

   bms_supply_switch i_supply_switch (
      .clk           (clk),
      .rst           (rst),
      .run_active    (mode_q == MODE_RUN),
      .ls_fall       (ls_fall),
      .vcc_gt_prot   (vcc_gt_prot),
      .vcc_gt_regon  (vcc_gt_regon),
      .vcc_lt_regoff (vcc_lt_regoff),
      .sw_q          (sw_q)
   );

   // ---------------- per-mode outputs ----------------
   always_comb begin
      hv_start_en  = 1'b0;
      ref_en       = 1'b0;
      ref_hi_cur   = 1'b0;
      ref_clamp_en = 1'b0;
      drv_en       = 1'b0;
      ocp_en       = 1'b0;
      sup_sw_on    = 1'b0;
      unique case (mode_q)
         MODE_START: begin
            hv_start_en  = 1'b1;
            ref_clamp_en = 1'b1;
         end
         MODE_SAVE: begin
            hv_start_en = hv_cyc_q;
            ref_en      = 1'b1;
         end
         MODE_RUN: begin
            ref_en     = 1'b1;
            ref_hi_cur = 1'b1;
            drv_en     = 1'b1;
            ocp_en     = 1'b1;
            sup_sw_on  = sw_q;
         end
         MODE_SHUT: begin
            hv_start_en  = 1'b1;
            ref_clamp_en = 1'b1;
         end
         default: ;
      endcase
   end

   assign mode = mode_q;

   // ---------------- assertions ----------------
   p_no_double_fall_r11: assert property (@(posedge clk) disable iff (rst)
      ls_fall |=> !ls_fall);

   p_hv_off_at_turn_on_r3: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_SAVE && vcc_gt_on) |=> (mode_q != MODE_SAVE) || !hv_start_en);

   p_save_exit_cause_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_START && $past(mode_q) == MODE_SAVE) |-> $past(vcc_lt_refoff));

   p_run_entry_qualified_r5: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_RUN && $past(mode_q) != MODE_RUN)
         |-> ($past(mode_q) == MODE_SAVE && $past(qual_done) && $past(ref_gt_hi)));

   p_timeout_exit_r7: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_SAVE && $past(mode_q) == MODE_RUN)
         |-> ($past(idle_done) && !$past(vcc_lt_off) && !$past(ref_lt_lo)));

   p_fault_to_shut_r8: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_RUN && (vcc_lt_off || ref_lt_lo)) |=> mode_q == MODE_SHUT);

   p_shut_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_SHUT) |=> (mode_q == MODE_START));

   p_switch_only_in_run_r12: assert property (@(posedge clk) disable iff (rst)
      (mode_q != MODE_RUN && $past(mode_q) != MODE_RUN) |-> !sw_q);

endmodule

// File: tb/test_ballast_mode_seq.sv
module test_ballast_mode_seq;

   localparam logic [8:0] F_ON    = 9'h100;
   localparam logic [8:0] F_SM    = 9'h080;
   localparam logic [8:0] F_OFFL  = 9'h040;
   localparam logic [8:0] F_RFL   = 9'h020;
   localparam logic [8:0] F_PROT  = 9'h010;
   localparam logic [8:0] F_RON   = 9'h008;
   localparam logic [8:0] F_ROFFL = 9'h004;
   localparam logic [8:0] F_RHI   = 9'h002;
   localparam logic [8:0] F_RLO   = 9'h001;

   typedef struct packed {
      logic [8:0]  fl;
      logic        ls;
      logic        hs;
      logic [31:0] cyc;
      logic [1:0]  mode;
      logic        hv;
      logic        psw;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t TAB [NV] = '{
      '{9'h000,                  1'b0, 1'b0, 32'd4,     2'd0, 1'b1, 1'b0, 8'd2 },  // R2 stay in start-up
      '{F_ON|F_SM,               1'b0, 1'b0, 32'd4,     2'd1, 1'b0, 1'b0, 8'd2 },  // R2 to save
      '{F_SM,                    1'b0, 1'b0, 32'd4,     2'd1, 1'b0, 1'b0, 8'd3 },  // R3 generator holds off
      '{9'h000,                  1'b0, 1'b0, 32'd4,     2'd1, 1'b1, 1'b0, 8'd3 },  // R3 below save level: on
      '{F_SM,                    1'b0, 1'b0, 32'd4,     2'd1, 1'b1, 1'b0, 8'd3 },  // R3 holds on
      '{F_ON|F_SM|F_RHI,         1'b0, 1'b1, 32'd1200,  2'd1, 1'b0, 1'b0, 8'd5 },  // R5 qualify, hs rising
      '{F_SM|F_RHI,              1'b0, 1'b0, 32'd6,     2'd2, 1'b0, 1'b0, 8'd5 },  // R5 hs fall enters run
      '{F_SM|F_RON|F_RHI,        1'b1, 1'b0, 32'd6,     2'd2, 1'b0, 1'b0, 8'd11},  // R11 rising edge no action
      '{F_SM|F_RON|F_RHI,        1'b0, 1'b0, 32'd6,     2'd2, 1'b0, 1'b1, 8'd11},  // R11 fall turns on
      '{F_SM|F_RHI,              1'b1, 1'b0, 32'd6,     2'd2, 1'b0, 1'b1, 8'd11},  // R11 hold
      '{F_SM|F_ROFFL|F_RHI,      1'b0, 1'b0, 32'd6,     2'd2, 1'b0, 1'b0, 8'd11},  // R11 fall turns off
      '{F_SM|F_PROT|F_RON|F_RHI, 1'b1, 1'b0, 32'd6,     2'd2, 1'b0, 1'b1, 8'd10},  // R10 immediate on
      '{F_SM|F_RHI,              1'b0, 1'b0, 32'd6,     2'd2, 1'b0, 1'b1, 8'd11},  // R11 fall, no flag: hold
      '{F_SM|F_RHI,              1'b0, 1'b0, 32'd10100, 2'd1, 1'b0, 1'b0, 8'd7 },  // R7 timeout, R12 switch off
      '{F_SM|F_RHI,              1'b0, 1'b1, 32'd6,     2'd1, 1'b0, 1'b0, 8'd5 },  // R5
      '{F_SM|F_RHI,              1'b0, 1'b0, 32'd6,     2'd1, 1'b0, 1'b0, 8'd5 },  // R5 edge too early
      '{F_SM,                    1'b0, 1'b1, 32'd1100,  2'd1, 1'b0, 1'b0, 8'd5 },  // R5 qualify again
      '{F_SM,                    1'b0, 1'b0, 32'd6,     2'd1, 1'b0, 1'b0, 8'd5 },  // R5 reference low
      '{F_SM|F_RHI,              1'b0, 1'b1, 32'd6,     2'd1, 1'b0, 1'b0, 8'd5 },  // R5
      '{F_SM|F_RHI,              1'b0, 1'b0, 32'd6,     2'd2, 1'b0, 1'b0, 8'd12},  // R12 cleared on entry
      '{F_SM|F_RLO,              1'b0, 1'b0, 32'd6,     2'd0, 1'b1, 1'b0, 8'd8 },  // R8 reference fault
      '{F_ON|F_SM,               1'b0, 1'b0, 32'd6,     2'd1, 1'b0, 1'b0, 8'd2 },  // R2
      '{F_RFL,                   1'b0, 1'b0, 32'd6,     2'd0, 1'b1, 1'b0, 8'd4 }   // R4 back to start-up
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] flg = '0;
   logic       ls = 1'b0, hs = 1'b0;
   logic [1:0] mode;
   logic       hv_start_en, ref_en, ref_hi_cur, ref_clamp_en, drv_en, ocp_en, sup_sw_on;

   int n_chk = 0;
   int n_err = 0;
   bit reported = 1'b0;

   always #5 clk = ~clk;

   ballast_mode_seq i_ballast_mode_seq (
      .clk           (clk),
      .rst           (rst),
      .vcc_gt_on     (flg[8]),
      .vcc_gt_save   (flg[7]),
      .vcc_lt_off    (flg[6]),
      .vcc_lt_refoff (flg[5]),
      .vcc_gt_prot   (flg[4]),
      .vcc_gt_regon  (flg[3]),
      .vcc_lt_regoff (flg[2]),
      .ref_gt_hi     (flg[1]),
      .ref_lt_lo     (flg[0]),
      .ls_in         (ls),
      .hs_in         (hs),
      .mode          (mode),
      .hv_start_en   (hv_start_en),
      .ref_en        (ref_en),
      .ref_hi_cur    (ref_hi_cur),
      .ref_clamp_en  (ref_clamp_en),
      .drv_en        (drv_en),
      .ocp_en        (ocp_en),
      .sup_sw_on     (sup_sw_on)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   // outputs that follow from the mode alone (R1 R3 R6 R9)
   task automatic chk_mode_outputs(input string tag, input int m);
      chk({tag, " ref_en"},   ref_en,       (m == 1 || m == 2) ? 1 : 0);
      chk({tag, " ref_hi"},   ref_hi_cur,   (m == 2) ? 1 : 0);
      chk({tag, " clamp"},    ref_clamp_en, (m == 0 || m == 3) ? 1 : 0);
      chk({tag, " drv_en"},   drv_en,       (m == 2) ? 1 : 0);
      chk({tag, " ocp_en"},   ocp_en,       (m == 2) ? 1 : 0);
   endtask

   task automatic chk_reset_state(input string tag);
      chk({tag, " mode"}, mode, 0);
      chk({tag, " hv"},   hv_start_en, 1);
      chk({tag, " sw"},   sup_sw_on, 0);
      chk_mode_outputs(tag, 0);
   endtask

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic go_run();
      flg = F_ON | F_SM | F_RHI;
      hs  = 1'b1;
      wait_cyc(1100);
      flg = F_SM | F_RHI;
      hs  = 1'b0;
      wait_cyc(6);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin : main
      wait_cyc(3);
      chk_reset_state("R1 during reset");
      rst = 1'b0;
      wait_cyc(1);
      chk_reset_state("R1 after reset");

      for (int i = 0; i < NV; i++) begin
         flg = TAB[i].fl;
         ls  = TAB[i].ls;
         hs  = TAB[i].hs;
         wait_cyc(int'(TAB[i].cyc));
         chk($sformatf("R%0d step %0d mode", TAB[i].req, i), mode, TAB[i].mode);
         chk($sformatf("R%0d step %0d hv", TAB[i].req, i), hv_start_en, TAB[i].hv);
         chk($sformatf("R%0d step %0d sw", TAB[i].req, i), sup_sw_on, TAB[i].psw);
         chk_mode_outputs($sformatf("R%0d/R3/R6 step %0d", TAB[i].req, i), TAB[i].mode);
      end

      // R4 reference-off exit coinciding with a qualified high-side fall
      flg = F_ON | F_SM | F_RHI;
      hs  = 1'b1;
      wait_cyc(1100);
      chk("R4 qualified save", mode, 1);
      flg = F_SM | F_RHI;
      hs  = 1'b0;
      wait_cyc(2);
      flg = F_RFL | F_RHI;
      wait_cyc(1);
      chk("R4 precedence over run entry", mode, 0);
      wait_cyc(2);
      chk("R4 stays start-up", mode, 0);

      // R9 shut-down state observed for one cycle, R10 switch on before it
      go_run();
      chk("R6 run entered", mode, 2);
      chk_mode_outputs("R6 run", 2);
      flg = F_SM | F_RHI | F_PROT;
      wait_cyc(3);
      chk("R10 switch on", sup_sw_on, 1);
      flg = F_SM | F_RHI | F_PROT | F_OFFL;
      wait_cyc(1);
      chk("R8 supply fault to shut-down", mode, 3);
      chk("R9 shut-down hv on", hv_start_en, 1);
      chk("R9 shut-down switch off", sup_sw_on, 0);
      chk_mode_outputs("R9 shut-down", 3);
      flg = F_SM;
      wait_cyc(1);
      chk("R9 shut-down lasts one clock", mode, 0);

      // R1 reset in operating mode
      go_run();
      chk("R1 precondition run", mode, 2);
      flg = '0;
      rst = 1'b1;
      wait_cyc(2);
      chk_reset_state("R1 mid-run reset");
      rst = 1'b0;
      wait_cyc(2);
      chk_reset_state("R1 after mid-run reset");

      report();
   end

endmodule